// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and the calendar date in packed BCD. A free-running oscillator enable, `osc_tick`, pulses once per cycle of a slow reference (nominally 32.768 kHz). A binary prescaler of `PRE_W` bits divides it into a once-per-second advance. The counters hold seconds, minutes, hours, weekday, day of month, month and a two-digit year. Hours run either in 24-hour form or in 12-hour form with a PM flag. Day of month follows each month's length. February gets a 29th day in every year 00..99 that is divisible by four.

Software reaches the block through a small register port: a write strobe, a 4-bit address, write data and combinational read data. A run bit gates counting, and the calendar registers can be loaded only while counting is halted. A carry flag is raised on every seconds advance. Software clears it before a multi-register read and checks it afterwards, so it can tell that a rollover happened in between and repeat the read. A second flag fires at a selectable binary fraction of a second. Each flag drives an interrupt line through its own enable bit. A self-clearing soft-reset bit reloads the calendar and restarts the prescaler.

Register map (address: content). 0 seconds [6:0]. 1 minutes [6:0]. 2 hours [5:0] with PM at bit 6. 3 weekday [2:0]. 4 day [5:0]. 5 month [4:0]. 6 year [7:0]. 8 interrupt control: carry enable bit 1, periodic enable bit 2, period select [7:4]. 9 run control: run bit 0, soft reset bit 1, 24-hour bit 6. 10 status: carry flag bit 1, periodic flag bit 2. Unlisted addresses and unlisted bits read 0.

Top module: `bcd_calendar`

## Requirements
- R1: After `rst_n` falls, address 0, 1 and 6 read 0x00, hours read 0x12 (12-hour mode, PM clear), weekday reads 0, day and month read 0x01, and addresses 8, 9 and 10 read 0x00.
- R2: With the run bit (address 9 bit 0) at 1, seconds advance once every 2^PRE_W cycles in which `osc_tick` is 1. While the run bit is 0, or while `osc_tick` stays 0, no counter moves.
- R3: Seconds and minutes count 0x00..0x59 in BCD; 0x59 wraps to 0x00 and advances the next field.
- R4: With address 9 bit 6 at 1, hours count 0x00..0x23, and 0x23 to 0x00 advances the date. With bit 6 at 0, hours count 0x12, 0x01 .. 0x11. PM (address 2 bit 6) toggles on the 0x11 to 0x12 step, and the step from 11 PM to 12 AM advances the date.
- R5: A date advance moves the weekday 0..6 with 6 wrapping to 0. It also moves the day, which wraps to 0x01 after the last day of the month: 0x30 for months 4, 6, 9, 11; 0x31 for other months; for February 0x29 when the year is divisible by 4 and 0x28 otherwise. Wrapping from month 0x12 gives 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R6: Writes to addresses 0..6 load the field (hours also load PM from bit 6) only while the run bit is 0; while it is 1 they are ignored.
- R7: The carry flag (address 10 bit 1) is set on every seconds advance. Writing address 10 with bit 1 at 0 clears it, and writing 1 there leaves it. A seconds advance in the same cycle as a clearing write leaves the flag set.
- R8: With period select code c (address 8 bits 7:4) in 1..PRE_W-1, the periodic flag (address 10 bit 2) is set once every 2^(c+1) counted oscillator pulses. Code 8 gives 1/64 s at 32.768 kHz. Other codes never set it. It clears like the carry flag, through bit 2.
- R9: `irq_carry` is the carry flag AND address 8 bit 1; `irq_period` is the periodic flag AND address 8 bit 2.
- R10: Writing address 9 with bit 1 set makes bit 1 read 1 for exactly one cycle, after which it reads 0. In that next cycle the calendar returns to its R1 values (hours 0x00 if the 24-hour bit is 1) and the prescaler restarts from zero. The run and 24-hour bits keep their written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable per reference oscillator period |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Combinational read data for `addr` |
| irq_carry | output | 1 | Carry interrupt request |
| irq_period | output | 1 | Periodic interrupt request |

## Verification
The functions that can collide are a seconds advance that sets the carry flag and a software write that clears it. The bench waits until its own model shows the prescaler one pulse short of wrapping, then issues the clearing status write. That write lands exactly on the edge that advances the seconds. The flag must read back as set, since the hardware event wins. A soft reset issued while counting runs is also checked: the pending reset must suppress that cycle's advance and restart the prescaler.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;

  localparam logic [3:0] A_SEC   = 4'h0;
  localparam logic [3:0] A_MIN   = 4'h1;
  localparam logic [3:0] A_HOUR  = 4'h2;
  localparam logic [3:0] A_WDAY  = 4'h3;
  localparam logic [3:0] A_DAY   = 4'h4;
  localparam logic [3:0] A_MON   = 4'h5;
  localparam logic [3:0] A_YEAR  = 4'h6;
  localparam logic [3:0] A_IRQC  = 4'h8;
  localparam logic [3:0] A_RUNC  = 4'h9;
  localparam logic [3:0] A_STAT  = 4'hA;

  localparam int SEL_CODES = 16;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic       pm;
  } tod_t;

  typedef struct packed {
    logic [2:0] wday;
    logic [5:0] day;
    logic [4:0] mon;
    logic [7:0] yr;
  } date_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [3:0] hi;
    hi = v[7:4] + 4'd1;
    if (v[3:0] >= 4'd9) return {hi, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_cal_prescale.sv
`timescale 1ns/1ps
module bcd_cal_prescale #(
  parameter int PRE_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [3:0] psel,
  output logic       sec_tick,
  output logic       per_hit
);
  import bcd_cal_pkg::*;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SEL_CODES-1:0] hit;

  assign hit[0] = 1'b0;
  for (genvar k = 1; k < SEL_CODES; k++) begin : g_sel
    if (k < PRE_W) begin : g_on
      assign hit[k] = &pre_q[k:0];
    end else begin : g_off
      assign hit[k] = 1'b0;
    end
  end

  assign sec_tick = run & (&pre_q);
  assign per_hit  = run & hit[psel];

  always_comb begin
    pre_d = pre_q;
    if (clr)      pre_d = '0;
    else if (run) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/bcd_cal_tod.sv
`timescale 1ns/1ps
module bcd_cal_tod (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                clr,
  input  logic                h24,
  input  logic                ld_sec,
  input  logic                ld_min,
  input  logic                ld_hr,
  input  logic [6:0]          wdata,
  output bcd_cal_pkg::tod_t   q,
  output logic                day_adv
);
  import bcd_cal_pkg::*;

  tod_t d;

  always_comb begin
    d       = q;
    day_adv = 1'b0;
    if (clr) begin
      d.sec = '0;
      d.min = '0;
      d.pm  = 1'b0;
      d.hr  = h24 ? 6'h00 : 6'h12;
    end else if (tick) begin
      if (q.sec != 7'h59) begin
        d.sec = 7'(bcd_inc({1'b0, q.sec}));
      end else begin
        d.sec = '0;
        if (q.min != 7'h59) begin
          d.min = 7'(bcd_inc({1'b0, q.min}));
        end else begin
          d.min = '0;
          if (h24) begin
            if (q.hr == 6'h23) begin
              d.hr    = 6'h00;
              day_adv = 1'b1;
            end else begin
              d.hr = 6'(bcd_inc({2'b0, q.hr}));
            end
          end else if (q.hr == 6'h11) begin
            d.hr    = 6'h12;
            d.pm    = ~q.pm;
            day_adv = q.pm;
          end else if (q.hr == 6'h12) begin
            d.hr = 6'h01;
          end else begin
            d.hr = 6'(bcd_inc({2'b0, q.hr}));
          end
        end
      end
    end else begin
      if (ld_sec) d.sec = wdata;
      if (ld_min) d.min = wdata;
      if (ld_hr) begin
        d.hr = wdata[5:0];
        d.pm = wdata[6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.sec <= '0;
      q.min <= '0;
      q.hr  <= 6'h12;
      q.pm  <= 1'b0;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/bcd_cal_date.sv
`timescale 1ns/1ps
module bcd_cal_date (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                clr,
  input  logic                ld_wday,
  input  logic                ld_day,
  input  logic                ld_mon,
  input  logic                ld_yr,
  input  logic [7:0]          wdata,
  output bcd_cal_pkg::date_t  q
);
  import bcd_cal_pkg::*;

  date_t d;

  always_comb begin
    d = q;
    if (clr) begin
      d.wday = '0;
      d.day  = 6'h01;
      d.mon  = 5'h01;
      d.yr   = 8'h00;
    end else if (adv) begin
      d.wday = (q.wday >= 3'd6) ? 3'd0 : q.wday + 3'd1;
      if (q.day != last_day(q.mon, q.yr)) begin
        d.day = 6'(bcd_inc({2'b0, q.day}));
      end else begin
        d.day = 6'h01;
        if (q.mon != 5'h12) begin
          d.mon = 5'(bcd_inc({3'b0, q.mon}));
        end else begin
          d.mon = 5'h01;
          d.yr  = (q.yr == 8'h99) ? 8'h00 : bcd_inc(q.yr);
        end
      end
    end else begin
      if (ld_wday) d.wday = wdata[2:0];
      if (ld_day)  d.day  = wdata[5:0];
      if (ld_mon)  d.mon  = wdata[4:0];
      if (ld_yr)   d.yr   = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.wday <= '0;
      q.day  <= 6'h01;
      q.mon  <= 5'h01;
      q.yr   <= 8'h00;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar #(
  parameter int PRE_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       we,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_carry,
  output logic       irq_period
);
  import bcd_cal_pkg::*;

  logic       start_q, start_d;
  logic       h24_q, h24_d;
  logic       srst_q, srst_d;
  logic       cie_q, cie_d;
  logic       pie_q, pie_d;
  logic [3:0] psel_q, psel_d;
  logic       cf_q, cf_d;
  logic       pf_q, pf_d;

  logic  run, sec_tick, per_hit, day_adv;
  logic  wr_irqc, wr_runc, wr_stat, cnt_wr_ok;
  tod_t  tod_q;
  date_t date_q;

  assign run       = start_q & osc_tick & ~srst_q;
  assign wr_irqc   = we && (addr == A_IRQC);
  assign wr_runc   = we && (addr == A_RUNC);
  assign wr_stat   = we && (addr == A_STAT);
  assign cnt_wr_ok = we && !start_q && !srst_q;

  bcd_cal_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clr      (srst_q),
    .psel     (psel_q),
    .sec_tick (sec_tick),
    .per_hit  (per_hit)
  );

  bcd_cal_tod u_tod (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sec_tick),
    .clr     (srst_q),
    .h24     (h24_q),
    .ld_sec  (cnt_wr_ok && (addr == A_SEC)),
    .ld_min  (cnt_wr_ok && (addr == A_MIN)),
    .ld_hr   (cnt_wr_ok && (addr == A_HOUR)),
    .wdata   (wdata[6:0]),
    .q       (tod_q),
    .day_adv (day_adv)
  );

  bcd_cal_date u_date (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (day_adv),
    .clr     (srst_q),
    .ld_wday (cnt_wr_ok && (addr == A_WDAY)),
    .ld_day  (cnt_wr_ok && (addr == A_DAY)),
    .ld_mon  (cnt_wr_ok && (addr == A_MON)),
    .ld_yr   (cnt_wr_ok && (addr == A_YEAR)),
    .wdata   (wdata),
    .q       (date_q)
  );

  // Control and status next state; a hardware set outranks a software clear.
  always_comb begin
    start_d = start_q;
    h24_d   = h24_q;
    cie_d   = cie_q;
    pie_d   = pie_q;
    psel_d  = psel_q;
    srst_d  = 1'b0;
    if (wr_runc) begin
      start_d = wdata[0];
      srst_d  = wdata[1];
      h24_d   = wdata[6];
    end
    if (wr_irqc) begin
      cie_d  = wdata[1];
      pie_d  = wdata[2];
      psel_d = wdata[7:4];
    end
    cf_d = cf_q;
    if (sec_tick)                cf_d = 1'b1;
    else if (wr_stat && !wdata[1]) cf_d = 1'b0;
    pf_d = pf_q;
    if (per_hit)                 pf_d = 1'b1;
    else if (wr_stat && !wdata[2]) pf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      h24_q   <= 1'b0;
      srst_q  <= 1'b0;
      cie_q   <= 1'b0;
      pie_q   <= 1'b0;
      psel_q  <= '0;
      cf_q    <= 1'b0;
      pf_q    <= 1'b0;
    end else begin
      start_q <= start_d;
      h24_q   <= h24_d;
      srst_q  <= srst_d;
      cie_q   <= cie_d;
      pie_q   <= pie_d;
      psel_q  <= psel_d;
      cf_q    <= cf_d;
      pf_q    <= pf_d;
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rdata = {1'b0, tod_q.sec};
      A_MIN:   rdata = {1'b0, tod_q.min};
      A_HOUR:  rdata = {1'b0, tod_q.pm, tod_q.hr};
      A_WDAY:  rdata = {5'b0, date_q.wday};
      A_DAY:   rdata = {2'b0, date_q.day};
      A_MON:   rdata = {3'b0, date_q.mon};
      A_YEAR:  rdata = date_q.yr;
      A_IRQC:  rdata = {psel_q, 1'b0, pie_q, cie_q, 1'b0};
      A_RUNC:  rdata = {1'b0, h24_q, 3'b0, 1'b0, srst_q, start_q};
      A_STAT:  rdata = {5'b0, pf_q, cf_q, 1'b0};
      default: rdata = 8'h00;
    endcase
  end

  assign irq_carry  = cf_q & cie_q;
  assign irq_period = pf_q & pie_q;
endmodule

// File: rtl/bcd_calendar_chk.sv
`timescale 1ns/1ps
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       we,
  input logic [3:0] addr,
  input logic       start,
  input logic       h24,
  input logic       srst,
  input logic       tick,
  input logic [6:0] sec,
  input logic [6:0] min,
  input logic [5:0] hour,
  input logic       pm,
  input logic       cf
);
  // R2: stopped counters hold unless loaded or soft-reset
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !srst && !(we && addr == 4'h0)) |=> $stable(sec));

  // R3: seconds wrap from 59 to 00
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sec == 7'h59) |=> (sec == 7'h00));

  // R4: PM toggles on the 11 to 12 step in 12-hour mode
  a_r4_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !h24 && sec == 7'h59 && min == 7'h59 && hour == 6'h11) |=> (pm != $past(pm)));

  // R6: running counters ignore writes
  a_r6_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !srst && !tick && we && addr == 4'h0) |=> $stable(sec));

  // R7: every seconds advance leaves the carry flag set
  a_r7_carry_set: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cf);

  // R10: a pending soft reset zeroes the time of day
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (sec == 7'h00 && min == 7'h00));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .we    (we),
  .addr  (addr),
  .start (start_q),
  .h24   (h24_q),
  .srst  (srst_q),
  .tick  (sec_tick),
  .sec   (tod_q.sec),
  .min   (tod_q.min),
  .hour  (tod_q.hr),
  .pm    (tod_q.pm),
  .cf    (cf_q)
);

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
  localparam int PRE_W = 10;
  localparam int PMAX  = (1 << PRE_W) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b1;
  logic       we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_carry, irq_period;

  always #10 clk = ~clk;

  bcd_calendar #(.PRE_W(PRE_W)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_carry(irq_carry), .irq_period(irq_period)
  );

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  // Behavioural reference state (binary integers)
  int m_sec, m_min, m_hr, m_pm, m_wd, m_day, m_mon, m_yr, m_pre;
  int m_start, m_h24, m_srst, m_cie, m_pie, m_psel, m_cf, m_pf;

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int from_bcd(int v);
    return (v >> 4) * 10 + (v & 15);
  endfunction
  function automatic int month_days(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic m_clear_cal();
    m_sec = 0; m_min = 0; m_pm = 0; m_hr = m_h24 ? 0 : 12;
    m_wd = 0; m_day = 1; m_mon = 1; m_yr = 0;
  endtask

  task automatic m_next_day();
    m_wd = (m_wd + 1) % 7;
    if (m_day == month_days(m_mon, m_yr)) begin
      m_day = 1;
      if (m_mon == 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
      else m_mon = m_mon + 1;
    end else m_day = m_day + 1;
  endtask

  task automatic m_next_sec();
    m_sec = m_sec + 1;
    if (m_sec < 60) return;
    m_sec = 0; m_min = m_min + 1;
    if (m_min < 60) return;
    m_min = 0;
    if (m_h24) begin
      m_hr = m_hr + 1;
      if (m_hr == 24) begin m_hr = 0; m_next_day(); end
    end else if (m_hr == 11) begin
      m_hr = 12; m_pm = 1 - m_pm;
      if (m_pm == 0) m_next_day();
    end else if (m_hr == 12) m_hr = 1;
    else m_hr = m_hr + 1;
  endtask

  function automatic int m_read(logic [3:0] a);
    case (a)
      4'h0: return to_bcd(m_sec);
      4'h1: return to_bcd(m_min);
      4'h2: return (m_pm << 6) | to_bcd(m_hr);
      4'h3: return m_wd;
      4'h4: return to_bcd(m_day);
      4'h5: return to_bcd(m_mon);
      4'h6: return to_bcd(m_yr);
      4'h8: return (m_psel << 4) | (m_pie << 2) | (m_cie << 1);
      4'h9: return (m_h24 << 6) | (m_srst << 1) | m_start;
      4'hA: return (m_pf << 2) | (m_cf << 1);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'h0, 4'h1: return "R3";
      4'h2:       return "R4";
      4'h3, 4'h4, 4'h5, 4'h6: return "R5";
      4'h8:       return "R8";
      4'h9:       return "R10";
      4'hA:       return "R7";
      default:    return "R1";
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit tk, ph;
    if (!rst_n) begin
      m_start = 0; m_h24 = 0; m_srst = 0; m_cie = 0; m_pie = 0; m_psel = 0;
      m_cf = 0; m_pf = 0; m_pre = 0;
      m_clear_cal();
    end else begin
      tk = 1'b0; ph = 1'b0;
      if (m_srst != 0) begin
        m_clear_cal(); m_pre = 0;
      end else if (m_start != 0 && osc_tick) begin
        tk = (m_pre == PMAX);
        ph = (m_psel >= 1 && m_psel < PRE_W && ((m_pre + 1) % (1 << (m_psel + 1))) == 0);
        m_pre = (m_pre + 1) & PMAX;
        if (tk) m_next_sec();
      end else if (we && m_start == 0) begin
        case (addr)
          4'h0: m_sec = from_bcd(wdata & 8'h7f);
          4'h1: m_min = from_bcd(wdata & 8'h7f);
          4'h2: begin m_hr = from_bcd(wdata & 8'h3f); m_pm = wdata[6]; end
          4'h3: m_wd = wdata & 8'h07;
          4'h4: m_day = from_bcd(wdata & 8'h3f);
          4'h5: m_mon = from_bcd(wdata & 8'h1f);
          4'h6: m_yr = from_bcd(wdata);
          default: ;
        endcase
      end
      if (tk) m_cf = 1;
      else if (we && addr == 4'hA && !wdata[1]) m_cf = 0;
      if (ph) m_pf = 1;
      else if (we && addr == 4'hA && !wdata[2]) m_pf = 0;
      m_srst = (we && addr == 4'h9) ? int'(wdata[1]) : 0;
      if (we && addr == 4'h9) begin m_start = wdata[0]; m_h24 = wdata[6]; end
      if (we && addr == 4'h8) begin
        m_cie = wdata[1]; m_pie = wdata[2]; m_psel = int'(wdata[7:4]);
      end
    end
  end

  task automatic chk(string t, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_of(addr), rdata, m_read(addr));
      chk("R9", irq_carry, m_cf & m_cie);
      chk("R9", irq_period, m_pf & m_pie);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, input int exp, input string t);
    @(negedge clk); #1;
    we = 1'b0; addr = a;
    @(negedge clk);
    chk(t, rdata, exp);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_pre(input int v);
    @(negedge clk);
    while (m_pre != v) @(negedge clk);
  endtask

  task automatic setup(input logic h, input logic [7:0] s, input logic [7:0] mi,
                       input logic [7:0] hr, input logic [7:0] wd, input logic [7:0] dy,
                       input logic [7:0] mo, input logic [7:0] yr);
    wr(4'h9, {1'b0, h, 4'b0, 2'b10});
    wr(4'h0, s); wr(4'h1, mi); wr(4'h2, hr); wr(4'h3, wd);
    wr(4'h4, dy); wr(4'h5, mo); wr(4'h6, yr);
    wr(4'h9, {1'b0, h, 4'b0, 2'b01});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    peek(4'h0, 8'h00, "R1"); peek(4'h2, 8'h12, "R1"); peek(4'h3, 0, "R1");
    peek(4'h4, 8'h01, "R1"); peek(4'h5, 8'h01, "R1"); peek(4'h6, 8'h00, "R1");
    peek(4'h8, 0, "R1"); peek(4'h9, 0, "R1"); peek(4'hA, 0, "R1");

    // R6 load while stopped
    wr(4'h0, 8'h45); peek(4'h0, 8'h45, "R6");

    // R3 R4 R5: 24-hour end of century
    setup(1'b1, 8'h58, 8'h59, 8'h23, 8'd6, 8'h31, 8'h12, 8'h99);
    waitc(1034); peek(4'h0, 8'h59, "R3");
    waitc(1024);
    peek(4'h0, 8'h00, "R3"); peek(4'h1, 8'h00, "R3"); peek(4'h2, 8'h00, "R4");
    peek(4'h3, 0, "R5"); peek(4'h4, 8'h01, "R5"); peek(4'h5, 8'h01, "R5");
    peek(4'h6, 8'h00, "R5");

    // R4 R5: 11 PM to 12 AM into leap day
    setup(1'b0, 8'h59, 8'h59, 8'h51, 8'd2, 8'h28, 8'h02, 8'h04);
    waitc(1034);
    peek(4'h2, 8'h12, "R4"); peek(4'h4, 8'h29, "R5"); peek(4'h3, 3, "R5");
    peek(4'h5, 8'h02, "R5");

    // R4: 11 AM to 12 PM keeps the date
    setup(1'b0, 8'h59, 8'h59, 8'h11, 8'd1, 8'h28, 8'h02, 8'h03);
    waitc(1034);
    peek(4'h2, 8'h52, "R4"); peek(4'h4, 8'h28, "R4");

    // R4: 12 PM to 1 PM
    setup(1'b0, 8'h59, 8'h59, 8'h52, 8'd1, 8'h10, 8'h07, 8'h20);
    waitc(1034);
    peek(4'h2, 8'h41, "R4"); peek(4'h4, 8'h10, "R4");

    // R5: non-leap February and a 30-day month
    setup(1'b1, 8'h59, 8'h59, 8'h23, 8'd0, 8'h28, 8'h02, 8'h03);
    waitc(1034);
    peek(4'h4, 8'h01, "R5"); peek(4'h5, 8'h03, "R5");
    setup(1'b1, 8'h59, 8'h59, 8'h23, 8'd0, 8'h30, 8'h04, 8'h10);
    waitc(1034);
    peek(4'h4, 8'h01, "R5"); peek(4'h5, 8'h05, "R5"); peek(4'h3, 1, "R5");

    // R6: write while running is ignored
    wr(4'h0, 8'h33); peek(4'h0, 8'h00, "R6");

    // R2: hold while stopped, and while osc_tick is low
    wr(4'h9, 8'h40); waitc(3000); peek(4'h0, 8'h00, "R2");
    wr(4'h9, 8'h41); osc_tick = 1'b0; waitc(3000); peek(4'h0, 8'h00, "R2");
    osc_tick = 1'b1;

    // R7 R9 carry flag
    wr(4'h8, 8'h02); waitc(1100);
    sync_pre(5);
    peek(4'hA, 8'h02, "R7"); chk("R9", irq_carry, 1);
    wr(4'hA, 8'hFF); peek(4'hA, 8'h02, "R7");
    wr(4'hA, 8'h00); peek(4'hA, 8'h00, "R7"); chk("R9", irq_carry, 0);
    sync_pre(PMAX - 1);
    wr(4'hA, 8'h00); peek(4'hA, 8'h02, "R7");

    // R8 R9 periodic flag
    sync_pre(3);
    wr(4'hA, 8'h00); wr(4'h8, 8'h84);
    waitc(600); peek(4'hA, 8'h04, "R8"); chk("R9", irq_period, 1);
    wr(4'hA, 8'h00); peek(4'hA, 8'h00, "R8");
    waitc(520); peek(4'hA, 8'h06, "R8");
    wr(4'h8, 8'hA4); wr(4'hA, 8'h00); waitc(2100); peek(4'hA, 8'h02, "R8");
    chk("R9", irq_period, 0);
    wr(4'h8, 8'h94); wr(4'hA, 8'h00); waitc(1100); peek(4'hA, 8'h06, "R8");

    // R10 soft reset while running in 24-hour mode
    sync_pre(5);
    wr(4'h9, 8'h43); chk("R10", rdata, 8'h43);
    @(negedge clk); chk("R10", rdata, 8'h41);
    peek(4'h2, 8'h00, "R10"); peek(4'h0, 8'h00, "R10"); peek(4'h4, 8'h01, "R10");
    peek(4'h9, 8'h41, "R10");

    waitc(4);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule